// File: doc/BRIEF.md
# Integer ALU with multiply/divide and operation decode

This block turns the opcode, funct3 and funct7 fields of an RV32 instruction into an internal operation code. It then applies that operation to two operands in the same cycle. It covers the register-register and register-immediate integer operations, the address additions used by loads, stores, lui and auipc, the compare subtraction used by branches, and the eight multiply/divide operations of the M extension. No clock or state is involved: the result follows the inputs combinationally.

For the register-register opcode, the decoder inspects funct7 first. The value 0000001 routes the instruction to the multiply/divide unit, and funct3 then picks one of the eight operations. Any other funct7 goes to the base unit, and bit 5 of funct7 picks between the alternative forms. Division follows the fixed results the instruction set defines for a zero divisor and for signed overflow, so no exception is raised.

Top module: `rv_alu_m`

## Requirements
- R1: With opcode 0110011 and funct7 not equal to 0000001, funct3 000..111 selects add, sll, slt, sltu, xor, srl, or, and. When funct7 bit 5 is 1, funct3 000 gives sub instead of add, and funct3 101 gives sra instead of srl.
- R2: With opcode 0110011 and funct7 equal to 0000001, funct3 000..111 selects mul, mulh, mulhsu, mulhu, div, divu, rem, remu in that order, whatever the base decode would give.
- R3: With opcode 0010011, funct3 maps as in R1, except that funct3 000 is always add. For funct3 101, funct7 bit 5 chooses sra (1) or srl (0).
- R4: Opcodes 0110111, 0010111, 0000011, 0100011, 1101111 and 1100111 select add, and opcode 1100011 selects sub. Every other opcode selects add.
- R5: The operation code output uses these values: add 0, sub 1, sll 2, slt 3, sltu 4, xor 5, srl 6, sra 7, or 8, and 9, mul 10, mulh 11, mulhsu 12, mulhu 13, div 14, divu 15, rem 16, remu 17.
- R6: The base operations give the XLEN-bit wrapped sum, difference and bitwise results. slt and sltu give 1 or 0 for a signed or unsigned less-than. Shifts use only the low log2(XLEN) bits of op2.
- R7: mul returns the low XLEN bits of the product.
- R8: mulh, mulhsu and mulhu return the upper XLEN bits of the 2*XLEN-bit product. mulh treats both operands as signed, mulhsu treats op1 as signed and op2 as unsigned, and mulhu treats both as unsigned.
- R9: div and divu truncate toward zero. rem and remu return a remainder that carries the sign of the dividend.
- R10: With op2 equal to zero, div and divu return all ones, and rem and remu return op1.
- R11: For signed division of the most negative value by -1, div returns op1 and rem returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Instruction opcode field |
| funct3 | input | 3 | Instruction funct3 field |
| funct7 | input | 7 | Instruction funct7 field |
| op1 | input | XLEN | First operand (rs1 side) |
| op2 | input | XLEN | Second operand (rs2 or immediate) |
| alu_op | output | 5 | Decoded operation code (R5) |
| result | output | XLEN | Operation result |

## Verification
The bench builds one instance with XLEN set to 8. That width makes the full dividend range affordable: every op1 value is swept against a corner set of op2 values for all eighteen operations, so the zero divisor, the -128 / -1 overflow and every mixed-sign product are reached. The expected results come from 64-bit integer arithmetic. A second instance at the default 32 bits takes directed corner values for the high-product and division rules. It also takes a sweep of the decode over all relevant opcodes, every funct3 and several funct7 patterns.

// File: rtl/rvalu_pkg.sv
package rvalu_pkg;

  typedef enum logic [4:0] {
    OP_ADD    = 5'd0,
    OP_SUB    = 5'd1,
    OP_SLL    = 5'd2,
    OP_SLT    = 5'd3,
    OP_SLTU   = 5'd4,
    OP_XOR    = 5'd5,
    OP_SRL    = 5'd6,
    OP_SRA    = 5'd7,
    OP_OR     = 5'd8,
    OP_AND    = 5'd9,
    OP_MUL    = 5'd10,
    OP_MULH   = 5'd11,
    OP_MULHSU = 5'd12,
    OP_MULHU  = 5'd13,
    OP_DIV    = 5'd14,
    OP_DIVU   = 5'd15,
    OP_REM    = 5'd16,
    OP_REMU   = 5'd17
  } alu_op_e;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  localparam logic [6:0] F7_MEXT    = 7'b0000001;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import rvalu_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output alu_op_e    op,
  output logic       is_mext
);

  // base group selection; alt picks sub (register form only) or sra
  function automatic alu_op_e base_sel(input logic [2:0] f3, input logic alt,
                                       input logic reg_form);
    alu_op_e r;
    case (f3)
      3'b000:  r = (alt && reg_form) ? OP_SUB : OP_ADD;
      3'b001:  r = OP_SLL;
      3'b010:  r = OP_SLT;
      3'b011:  r = OP_SLTU;
      3'b100:  r = OP_XOR;
      3'b101:  r = alt ? OP_SRA : OP_SRL;
      3'b110:  r = OP_OR;
      default: r = OP_AND;
    endcase
    return r;
  endfunction

  function automatic alu_op_e mext_sel(input logic [2:0] f3);
    alu_op_e r;
    case (f3)
      3'b000:  r = OP_MUL;
      3'b001:  r = OP_MULH;
      3'b010:  r = OP_MULHSU;
      3'b011:  r = OP_MULHU;
      3'b100:  r = OP_DIV;
      3'b101:  r = OP_DIVU;
      3'b110:  r = OP_REM;
      default: r = OP_REMU;
    endcase
    return r;
  endfunction

  always_comb begin
    op      = OP_ADD;
    is_mext = 1'b0;
    case (opcode)
      OPC_REG: begin
        if (funct7 == F7_MEXT) begin
          is_mext = 1'b1;
          op      = mext_sel(funct3);
        end else begin
          op      = base_sel(funct3, funct7[5], 1'b1);
        end
      end
      OPC_IMM:    op = base_sel(funct3, funct7[5], 1'b0);
      OPC_BRANCH: op = OP_SUB;
      default:    op = OP_ADD;
    endcase
  end

endmodule

// File: rtl/alu_base.sv
module alu_base
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y
);

  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] shamt;
  logic           lt_s;
  logic           lt_u;

  assign shamt = b[SHW-1:0];
  assign lt_s  = $signed(a) < $signed(b);
  assign lt_u  = a < b;

  always_comb begin
    case (op)
      OP_SUB:  y = a - b;
      OP_SLL:  y = a << shamt;
      OP_SLT:  y = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU: y = {{(XLEN-1){1'b0}}, lt_u};
      OP_XOR:  y = a ^ b;
      OP_SRL:  y = a >> shamt;
      OP_SRA:  y = XLEN'($signed(a) >>> shamt);
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y,
  output logic             div_zero,
  output logic             div_ovf
);

  localparam int PW = 2 * XLEN;
  localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  // full product; each operand extended as signed or unsigned
  function automatic logic [PW-1:0] wide_mul(input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] z,
                                             input logic sx, input logic sz);
    logic [PW-1:0] ex;
    logic [PW-1:0] ez;
    ex = {{XLEN{sx & x[XLEN-1]}}, x};
    ez = {{XLEN{sz & z[XLEN-1]}}, z};
    return ex * ez;
  endfunction

  function automatic logic [XLEN-1:0] quot_s(input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] z);
    logic signed [XLEN-1:0] sx;
    logic signed [XLEN-1:0] sz;
    sx = x;
    sz = z;
    if (z == '0)                           return ALL_ONES;
    else if (x == MOST_NEG && z == ALL_ONES) return x;
    else                                   return sx / sz;
  endfunction

  function automatic logic [XLEN-1:0] rem_s(input logic [XLEN-1:0] x,
                                            input logic [XLEN-1:0] z);
    logic signed [XLEN-1:0] sx;
    logic signed [XLEN-1:0] sz;
    sx = x;
    sz = z;
    if (z == '0)                           return x;
    else if (x == MOST_NEG && z == ALL_ONES) return '0;
    else                                   return sx % sz;
  endfunction

  function automatic logic [XLEN-1:0] quot_u(input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] z);
    if (z == '0) return ALL_ONES;
    else         return x / z;
  endfunction

  function automatic logic [XLEN-1:0] rem_u(input logic [XLEN-1:0] x,
                                            input logic [XLEN-1:0] z);
    if (z == '0) return x;
    else         return x % z;
  endfunction

  logic [PW-1:0] prod;
  logic          sgn_a;
  logic          sgn_b;

  assign sgn_a    = (op == OP_MULH) || (op == OP_MULHSU);
  assign sgn_b    = (op == OP_MULH);
  assign prod     = wide_mul(a, b, sgn_a, sgn_b);
  assign div_zero = (b == '0);
  assign div_ovf  = (a == MOST_NEG) && (b == ALL_ONES);

  always_comb begin
    case (op)
      OP_MUL:                     y = prod[XLEN-1:0];
      OP_MULH, OP_MULHSU,
      OP_MULHU:                   y = prod[PW-1:XLEN];
      OP_DIV:                     y = quot_s(a, b);
      OP_DIVU:                    y = quot_u(a, b);
      OP_REM:                     y = rem_s(a, b);
      OP_REMU:                    y = rem_u(a, b);
      default:                    y = prod[XLEN-1:0];
    endcase
  end

endmodule

// File: rtl/rv_alu_m.sv
module rv_alu_m
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [6:0]       opcode,
  input  logic [2:0]       funct3,
  input  logic [6:0]       funct7,
  input  logic [XLEN-1:0]  op1,
  input  logic [XLEN-1:0]  op2,
  output logic [4:0]       alu_op,
  output logic [XLEN-1:0]  result
);

  alu_op_e         dec_op;
  logic            is_mext;
  logic [XLEN-1:0] base_y;
  logic [XLEN-1:0] md_y;
  logic            div_zero;
  logic            div_ovf;

  alu_decode u_dec (
    .opcode  (opcode),
    .funct3  (funct3),
    .funct7  (funct7),
    .op      (dec_op),
    .is_mext (is_mext)
  );

  alu_base #(.XLEN(XLEN)) u_base (
    .op (dec_op),
    .a  (op1),
    .b  (op2),
    .y  (base_y)
  );

  alu_muldiv #(.XLEN(XLEN)) u_md (
    .op       (dec_op),
    .a        (op1),
    .b        (op2),
    .y        (md_y),
    .div_zero (div_zero),
    .div_ovf  (div_ovf)
  );

  assign alu_op = dec_op;
  assign result = is_mext ? md_y : base_y;

endmodule

// File: rtl/rv_alu_m_chk.sv
module rv_alu_m_chk
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic [6:0]      opcode,
  input logic [2:0]      funct3,
  input logic [6:0]      funct7,
  input logic [XLEN-1:0] op1,
  input logic [XLEN-1:0] op2,
  input logic [4:0]      alu_op,
  input logic [XLEN-1:0] result,
  input logic            is_mext,
  input logic            div_zero,
  input logic            div_ovf
);

  logic known;
  assign known = !$isunknown({opcode, funct3, funct7, op1, op2});

  always_comb begin
    if (known) begin
      // R2: multiply/divide group reached only through funct7 0000001
      if (opcode == OPC_REG && funct7 == F7_MEXT)
        p_mext_route_r2: assert (is_mext && alu_op >= 5'd10 && alu_op <= 5'd17)
          else $error("mext routing");
      // R1: other funct7 values stay in the base group
      if (opcode == OPC_REG && funct7 != F7_MEXT)
        p_base_route_r1: assert (!is_mext && alu_op <= 5'd9)
          else $error("base routing");
      // R4: address-forming opcodes add
      if (opcode == OPC_LUI || opcode == OPC_AUIPC || opcode == OPC_LOAD ||
          opcode == OPC_STORE)
        p_addr_add_r4: assert (alu_op == 5'd0) else $error("address add");
      // R10: zero divisor quotient
      if (div_zero && (alu_op == 5'd14 || alu_op == 5'd15))
        p_divz_quot_r10: assert (result == {XLEN{1'b1}}) else $error("div by zero");
      // R10: zero divisor remainder
      if (div_zero && (alu_op == 5'd16 || alu_op == 5'd17))
        p_divz_rem_r10: assert (result == op1) else $error("rem by zero");
      // R11: signed overflow
      if (div_ovf && alu_op == 5'd14)
        p_ovf_quot_r11: assert (result == op1) else $error("div overflow");
      if (div_ovf && alu_op == 5'd16)
        p_ovf_rem_r11: assert (result == '0) else $error("rem overflow");
    end
  end

endmodule

bind rv_alu_m rv_alu_m_chk #(.XLEN(XLEN)) u_chk (
  .opcode   (opcode),
  .funct3   (funct3),
  .funct7   (funct7),
  .op1      (op1),
  .op2      (op2),
  .alu_op   (alu_op),
  .result   (result),
  .is_mext  (is_mext),
  .div_zero (div_zero),
  .div_ovf  (div_ovf)
);

// File: tb/rv_alu_m_test.sv
module rv_alu_m_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // narrow instance for sweeps
  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [7:0] a8, b8, r8;
  logic [4:0] op8;

  rv_alu_m #(.XLEN(8)) uut (
    .opcode(opc), .funct3(f3), .funct7(f7),
    .op1(a8), .op2(b8), .alu_op(op8), .result(r8)
  );

  // full-width instance for directed corners and decode
  logic [6:0]  opc32, f732;
  logic [2:0]  f332;
  logic [31:0] a32, b32, r32;
  logic [4:0]  op32;

  rv_alu_m uut32 (
    .opcode(opc32), .funct3(f332), .funct7(f732),
    .op1(a32), .op2(b32), .alu_op(op32), .result(r32)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected op code, written from the requirement tables
  function automatic int want_op(input logic [6:0] oc, input logic [2:0] g3,
                                 input logic [6:0] g7);
    int base_map [8] = '{0, 2, 3, 4, 5, 6, 8, 9};
    int v;
    if (oc == 7'h33) begin
      if (g7 == 7'h01) return 10 + int'(g3);
      v = base_map[g3];
      if (g7[5] && g3 == 3'd0) v = 1;
      if (g7[5] && g3 == 3'd5) v = 7;
      return v;
    end else if (oc == 7'h13) begin
      v = base_map[g3];
      if (g7[5] && g3 == 3'd5) v = 7;
      return v;
    end else if (oc == 7'h63) begin
      return 1;
    end
    return 0;
  endfunction

  // expected 8-bit result using 64-bit integer arithmetic
  function automatic logic [7:0] want_res(input int k, input logic [7:0] x,
                                          input logic [7:0] z);
    longint sx = longint'($signed(x));
    longint sz = longint'($signed(z));
    longint ux = longint'(x);
    longint uz = longint'(z);
    int     sh = int'(z[2:0]);
    longint r;
    case (k)
      0:  r = ux + uz;
      1:  r = ux - uz;
      2:  r = ux << sh;
      3:  r = (sx < sz) ? 1 : 0;
      4:  r = (ux < uz) ? 1 : 0;
      5:  r = ux ^ uz;
      6:  r = ux >> sh;
      7:  r = sx >>> sh;
      8:  r = ux | uz;
      9:  r = ux & uz;
      10: r = ux * uz;
      11: r = (sx * sz) >>> 8;
      12: r = (sx * uz) >>> 8;
      13: r = (ux * uz) >> 8;
      14: r = (uz == 0) ? -1 : (sx == -128 && sz == -1) ? sx : sx / sz;
      15: r = (uz == 0) ? -1 : ux / uz;
      16: r = (uz == 0) ? sx : (sx == -128 && sz == -1) ? 0 : sx % sz;
      default: r = (uz == 0) ? ux : ux % uz;
    endcase
    return r[7:0];
  endfunction

  function automatic string req_of(input int k);
    if (k == 10) return "R7";
    if (k >= 11 && k <= 13) return "R8";
    if (k >= 14) return "R9/R10/R11";
    return "R6";
  endfunction

  task automatic run32(input logic [2:0] g3, input logic [6:0] g7,
                       input logic [31:0] x, input logic [31:0] z,
                       input logic [31:0] exp, input string req);
    opc32 = 7'h33; f332 = g3; f732 = g7; a32 = x; b32 = z;
    #1;
    chk(req, r32, exp);
    #1;
  endtask

  initial begin
    logic [7:0] bset [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h08, 8'h7f, 8'h80,
                              8'h81, 8'hfe, 8'hff, 8'h05, 8'h55, 8'haa, 8'h10, 8'h40};
    logic [6:0] ocset [11] = '{7'h33, 7'h13, 7'h37, 7'h17, 7'h03, 7'h23, 7'h63,
                               7'h6f, 7'h67, 7'h7f, 7'h0f};
    logic [6:0] f7set [5] = '{7'h00, 7'h20, 7'h01, 7'h7f, 7'h21};

    // initial state: add decode, zero result (R4, R5)
    opc = 7'h03; f3 = 3'd0; f7 = 7'h00; a8 = 8'h00; b8 = 8'h00;
    opc32 = 7'h37; f332 = 3'd0; f732 = 7'h00; a32 = '0; b32 = '0;
    #2;
    chk("R4 initial op", 32'(op32), 32'd0);
    chk("R4 initial result", r32, 32'd0);

    // decode sweep (R1, R2, R3, R4, R5)
    for (int i = 0; i < 11; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 5; m++) begin
          opc32 = ocset[i]; f332 = 3'(j); f732 = f7set[m];
          #1;
          chk("R1/R2/R3/R4/R5 decode", 32'(op32), 32'(want_op(ocset[i], 3'(j), f7set[m])));
          #1;
        end

    // immediate form: funct3 000 stays add with funct7 bit 5 set (R3)
    opc32 = 7'h13; f332 = 3'd0; f732 = 7'h20; a32 = 32'd9; b32 = 32'd4;
    #1; chk("R3 addi ignores funct7", r32, 32'd13); #1;

    // result sweep over narrow width (R6..R11)
    for (int k = 0; k < 18; k++) begin
      logic [2:0] g3;
      logic [6:0] g7;
      if (k >= 10) begin
        g3 = 3'(k - 10); g7 = 7'h01;
      end else begin
        case (k)
          0: g3 = 3'd0; 1: g3 = 3'd0; 2: g3 = 3'd1; 3: g3 = 3'd2; 4: g3 = 3'd3;
          5: g3 = 3'd4; 6: g3 = 3'd5; 7: g3 = 3'd5; 8: g3 = 3'd6; default: g3 = 3'd7;
        endcase
        g7 = (k == 1 || k == 7) ? 7'h20 : 7'h00;
      end
      opc = 7'h33; f3 = g3; f7 = g7;
      for (int x = 0; x < 256; x++)
        for (int n = 0; n < 16; n++) begin
          a8 = 8'(x); b8 = bset[n];
          #1;
          chk({req_of(k), " narrow"}, 32'(r8), 32'(want_res(k, 8'(x), bset[n])));
          if (op8 != 5'(k)) chk("R5 narrow op", 32'(op8), 32'(k));
        end
    end

    // full-width corners
    run32(3'd1, 7'h01, 32'hffffffff, 32'hffffffff, 32'h00000000, "R8 mulh -1*-1");
    run32(3'd3, 7'h01, 32'hffffffff, 32'hffffffff, 32'hfffffffe, "R8 mulhu max");
    run32(3'd2, 7'h01, 32'hffffffff, 32'hffffffff, 32'hffffffff, "R8 mulhsu");
    run32(3'd0, 7'h01, 32'h00010001, 32'h00010001, 32'h00020001, "R7 mul low");
    run32(3'd4, 7'h01, 32'h80000000, 32'hffffffff, 32'h80000000, "R11 div overflow");
    run32(3'd6, 7'h01, 32'h80000000, 32'hffffffff, 32'h00000000, "R11 rem overflow");
    run32(3'd5, 7'h01, 32'h12345678, 32'h00000000, 32'hffffffff, "R10 divu by zero");
    run32(3'd4, 7'h01, 32'h12345678, 32'h00000000, 32'hffffffff, "R10 div by zero");
    run32(3'd7, 7'h01, 32'h00000007, 32'h00000000, 32'h00000007, "R10 remu by zero");
    run32(3'd6, 7'h01, 32'hfffffff9, 32'h00000000, 32'hfffffff9, "R10 rem by zero");
    run32(3'd4, 7'h01, 32'hfffffff9, 32'h00000002, 32'hfffffffd, "R9 div -7/2");
    run32(3'd6, 7'h01, 32'hfffffff9, 32'h00000002, 32'hffffffff, "R9 rem -7%2");
    run32(3'd5, 7'h20, 32'h80000000, 32'h0000003f, 32'hffffffff, "R6 sra uses low bits");
    run32(3'd1, 7'h00, 32'h00000001, 32'h00000021, 32'h00000002, "R6 sll uses low bits");
    run32(3'd0, 7'h20, 32'h00000000, 32'h00000001, 32'hffffffff, "R1 sub wraps");
    run32(3'd0, 7'h21, 32'h00000005, 32'h00000003, 32'h00000002, "R1 bit5 sub");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule